// File: doc/BRIEF.md
# Serial Conversion Result Output Port

This block is the device-side output stage of a 14-bit sampling converter. A parallel conversion result arrives with a one-cycle valid strobe and is held until a host opens a frame. The block then sends the word serially, most significant bit first, on a data line that a pad tri-states using the block's output-enable signal. The host provides the serial clock, an active-low chip select and a frame-sync line. The host reads each bit on a falling serial-clock edge, and the block moves to the next bit on the rising edge.

Each frame uses one of two framings. The block samples the frame-sync level at the moment chip select falls. If frame sync is high there (it is tied high when unused), chip select alone opens the frame. If frame sync is low, the block waits with its output off until frame sync rises. The output is released after the 17th rising serial-clock edge of the frame, or earlier when chip select returns high. All three host pins pass through synchronizers and edge detectors clocked by a faster system clock. Every output update therefore happens in that clock domain, a few cycles after the pin edge.

Top module: `adc_result_serializer`

## Requirements
- R1: While reset is asserted and immediately after it, `sdoEn` and `sdo` are both 0.
- R2: While the synchronized chip select is high, `sdoEn` is 0 and `sdo` is 0. After chip select rises, the output is released within four system-clock cycles. `sdo` is also 0 whenever `sdoEn` is 0.
- R3: If `fsync` is 1 when `csN` falls, `sdoEn` becomes 1 within four system-clock cycles. `sdo` then shows result bit 13, with no serial-clock edge needed.
- R4: If `fsync` is 0 when `csN` falls, `sdoEn` stays 0 until `fsync` rises. `sdoEn` then becomes 1 within four cycles, with `sdo` showing result bit 13.
- R5: The frame word is 16 bits: the 14-bit result, MSB first, followed by two 0 bits. The first rising serial-clock edge of a frame keeps the MSB on `sdo`. Rising edges 2 to 16 each move to the next bit. Between rising edges, `sdo` and `sdoEn` do not change.
- R6: The 17th rising serial-clock edge of a frame drives `sdoEn` to 0. Later serial-clock edges leave it at 0 until chip select has risen and fallen again.
- R7: If chip select rises before the 17th rising edge, `sdoEn` drops to 0 within four cycles.
- R8: The result word is copied into the output shifter only when a frame opens. A `resultValid` strobe during a frame does not alter the word being sent, and the next frame sends the new value.
- R9: Once a frame is open, `fsync` edges have no effect on the word or on `sdoEn`.
- R10: `sdoEn` rises only in the cycle after a frame-opening event: a chip-select fall with frame sync high, or a frame-sync rise while armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| resultData | input | 14 | Parallel conversion result |
| resultValid | input | 1 | One-cycle strobe that captures `resultData` |
| csN | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| fsync | input | 1 | Frame sync, asynchronous; held high when unused |
| sdo | output | 1 | Serial data bit, 0 while not enabled |
| sdoEn | output | 1 | Enable for the data pad's tri-state driver |

## Verification
Frames alternate between chip-select framing and frame-sync framing, with random result values plus all-ones and single-bit values. Together these separate bit-order and padding errors from mode-selection errors. Each framing is closed both by a 17th clock edge and by an early or on-time chip-select rise, which shows whether the two release paths are independent. Three further patterns target specific faults. A result update in mid-frame shows whether the shifter is loaded too eagerly. Frame-sync toggles inside an open frame show whether mode state leaks past frame start. Extra clock edges after release show whether the released state is sticky.

// File: rtl/adc_ser_pkg.sv
`timescale 1ns/1ps
package adc_ser_pkg;

  // Strobes from the control FSM to the datapath, one cycle wide each.
  typedef struct packed {
    logic load;   // copy the held result into the shifter
    logic shift;  // advance the shifter by one bit
    logic clear;  // empty the shifter so the data line idles low
  } serStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,  // deselected
    ST_ARMED   = 2'd1,  // selected, waiting for a frame-sync rise
    ST_SHIFT   = 2'd2,  // output enabled, counting clock edges
    ST_DRAINED = 2'd3   // released, waiting for deselect
  } serState_t;

endpackage

// File: rtl/adc_edge_sync.sv
`timescale 1ns/1ps
module adc_edge_sync #(
  parameter int                 LANES     = 3,
  parameter int                 STAGES    = 2,
  parameter logic [LANES-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] rawIn,
  output logic [LANES-1:0] lvl,
  output logic [LANES-1:0] chg
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] pipe;
    logic              prevLvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe    <= {STAGES{RESET_VAL[g]}};
        prevLvl <= RESET_VAL[g];
      end else begin
        pipe    <= {pipe[STAGES-2:0], rawIn[g]};
        prevLvl <= pipe[STAGES-1];
      end
    end

    assign lvl[g] = pipe[STAGES-1];
    assign chg[g] = pipe[STAGES-1] ^ prevLvl;
  end

endmodule

// File: rtl/adc_ser_ctrl.sv
`timescale 1ns/1ps
module adc_ser_ctrl
  import adc_ser_pkg::*;
#(
  parameter int RELEASE_EDGE = 17,
  parameter int CNT_W        = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csLvl,
  input  logic       csChg,
  input  logic       fsLvl,
  input  logic       fsChg,
  input  logic       sclkLvl,
  input  logic       sclkChg,
  output serStrobe_t strobe,
  output logic       sdoEn
);

  serState_t        state, stateNext;
  logic [CNT_W-1:0] edgeCnt, edgeCntNext;
  logic             enNext;

  logic csRise, csFall, fsRise, sclkRise;
  logic [CNT_W-1:0] edgeInc;

  assign csRise   = csChg & csLvl;
  assign csFall   = csChg & ~csLvl;
  assign fsRise   = fsChg & fsLvl;
  assign sclkRise = sclkChg & sclkLvl;
  assign edgeInc  = edgeCnt + CNT_W'(1);

  always_comb begin
    stateNext   = state;
    edgeCntNext = edgeCnt;
    enNext      = sdoEn;
    strobe      = '0;

    if (csRise) begin
      stateNext    = ST_IDLE;
      enNext       = 1'b0;
      strobe.clear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (csFall) begin
            if (fsLvl) begin
              stateNext   = ST_SHIFT;
              enNext      = 1'b1;
              strobe.load = 1'b1;
              edgeCntNext = sclkRise ? CNT_W'(1) : '0;
            end else begin
              stateNext = ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (fsRise) begin
            stateNext   = ST_SHIFT;
            enNext      = 1'b1;
            strobe.load = 1'b1;
            edgeCntNext = sclkRise ? CNT_W'(1) : '0;
          end
        end
        ST_SHIFT: begin
          if (sclkRise) begin
            edgeCntNext = edgeInc;
            if (edgeInc == CNT_W'(RELEASE_EDGE)) begin
              stateNext    = ST_DRAINED;
              enNext       = 1'b0;
              strobe.clear = 1'b1;
            end else if (edgeCnt != '0) begin
              strobe.shift = 1'b1;
            end
          end
        end
        default: ; // ST_DRAINED: wait for deselect
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
      sdoEn   <= 1'b0;
    end else begin
      state   <= stateNext;
      edgeCnt <= edgeCntNext;
      sdoEn   <= enNext;
    end
  end

endmodule

// File: rtl/adc_ser_data.sv
`timescale 1ns/1ps
module adc_ser_data
  import adc_ser_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] resultData,
  input  logic              resultValid,
  input  serStrobe_t        strobe,
  output logic              sdo
);

  localparam int WORD_W = DATA_W + PAD_W;

  logic [DATA_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           holdReg <= '0;
    else if (resultValid) holdReg <= resultData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shiftReg <= '0;
    else if (strobe.clear) shiftReg <= '0;
    else if (strobe.load)  shiftReg <= {holdReg, {PAD_W{1'b0}}};
    else if (strobe.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
  end

  assign sdo = shiftReg[WORD_W-1];

endmodule

// File: rtl/adc_result_serializer.sv
`timescale 1ns/1ps
module adc_result_serializer
  import adc_ser_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] resultData,
  input  logic              resultValid,
  input  logic              csN,
  input  logic              sclk,
  input  logic              fsync,
  output logic              sdo,
  output logic              sdoEn
);

  localparam int WORD_W       = DATA_W + PAD_W;
  localparam int RELEASE_EDGE = WORD_W + 1;
  localparam int CNT_W        = $clog2(RELEASE_EDGE + 1);

  // lane order: 0 = chip select, 1 = frame sync, 2 = serial clock
  localparam logic [2:0] PIN_IDLE = 3'b011;

  logic [2:0] syncLvl, syncChg;
  logic       csLvl, csChg, fsLvl, fsChg, sclkLvl, sclkChg;
  serStrobe_t strobe;

  adc_edge_sync #(
    .LANES    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .rawIn({sclk, fsync, csN}),
    .lvl  (syncLvl),
    .chg  (syncChg)
  );

  assign csLvl   = syncLvl[0];
  assign csChg   = syncChg[0];
  assign fsLvl   = syncLvl[1];
  assign fsChg   = syncChg[1];
  assign sclkLvl = syncLvl[2];
  assign sclkChg = syncChg[2];

  adc_ser_ctrl #(
    .RELEASE_EDGE(RELEASE_EDGE),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .csLvl  (csLvl),
    .csChg  (csChg),
    .fsLvl  (fsLvl),
    .fsChg  (fsChg),
    .sclkLvl(sclkLvl),
    .sclkChg(sclkChg),
    .strobe (strobe),
    .sdoEn  (sdoEn)
  );

  adc_ser_data #(
    .DATA_W(DATA_W),
    .PAD_W (PAD_W)
  ) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .resultData (resultData),
    .resultValid(resultValid),
    .strobe     (strobe),
    .sdo        (sdo)
  );

endmodule

// File: rtl/adc_result_serializer_chk.sv
`timescale 1ns/1ps
module adc_result_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic csLvl,
  input logic csChg,
  input logic fsLvl,
  input logic fsChg,
  input logic sclkLvl,
  input logic sclkChg,
  input logic sdo,
  input logic sdoEn
);

  // R2: deselected means output off and line low
  p_quiet_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csLvl |=> (!sdoEn && !sdo));

  // R2: the data line idles low whenever the driver is off
  p_low_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sdoEn |-> !sdo);

  // R3: select with frame sync high opens the frame at once
  p_spi_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csChg && !csLvl && fsLvl) |=> sdoEn);

  // R4: select with frame sync low keeps the output off
  p_dsp_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (csChg && !csLvl && !fsLvl) |=> !sdoEn);

  // R5: no rising clock edge and still selected -> nothing moves
  p_hold_between_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdoEn && !csLvl && !(sclkChg && sclkLvl)) |=> (sdoEn && $stable(sdo)));

  // R10: enable only follows a frame-opening event
  p_open_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdoEn) |-> $past((csChg && !csLvl && fsLvl) || (fsChg && fsLvl)));

endmodule

bind adc_result_serializer adc_result_serializer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .csLvl  (csLvl),
  .csChg  (csChg),
  .fsLvl  (fsLvl),
  .fsChg  (fsChg),
  .sclkLvl(sclkLvl),
  .sclkChg(sclkChg),
  .sdo    (sdo),
  .sdoEn  (sdoEn)
);

// File: tb/adc_result_serializer_test.sv
`timescale 1ns/1ps
module adc_result_serializer_test;

  localparam int HALF  = 6;       // system clocks per serial-clock phase
  localparam int LAT   = 6;       // wait after a pin change before sampling
  localparam int LIMIT = 100000;  // watchdog in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] resultData = '0;
  logic        resultValid = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        fsync = 1'b1;
  logic        sdo, sdoEn;

  int          vectors = 0;
  int          miscompares = 0;
  int          cycles = 0;
  bit          done = 1'b0;
  logic [15:0] got;

  always #2 clk = ~clk;  // 250 MHz

  adc_result_serializer uut (
    .clk(clk), .rst_n(rst_n), .resultData(resultData), .resultValid(resultValid),
    .csN(csN), .sclk(sclk), .fsync(fsync), .sdo(sdo), .sdoEn(sdoEn)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == LIMIT && !done) begin
      vectors++;
      miscompares++;
      $display("FAIL R5 watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [15:0] expWord(logic [13:0] v);
    return {v, 2'b00};
  endfunction

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadResult(logic [13:0] v);
    resultData  = v;
    resultValid = 1'b1;
    waitCyc(1);
    resultValid = 1'b0;
    waitCyc(2);
  endtask

  // one serial-clock period; sdo is read late in the high phase
  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      waitCyc(HALF);
      got = {got[14:0], sdo};
      sclk = 1'b0;
      waitCyc(HALF);
    end
  endtask

  task automatic openFrame(bit dsp, logic [13:0] v);
    got = '0;
    if (dsp) begin
      fsync = 1'b0;
      waitCyc(LAT);
      csN = 1'b0;
      waitCyc(LAT);
      check("R4", "armed enable", {31'd0, sdoEn}, 32'd0);
      fsync = 1'b1;
      waitCyc(LAT);
      check("R4", "fs open en/msb", {30'd0, sdoEn, sdo}, {30'd0, 1'b1, v[13]});
    end else begin
      fsync = 1'b1;
      waitCyc(2);
      csN = 1'b0;
      waitCyc(LAT);
      check("R3", "cs open en/msb", {30'd0, sdoEn, sdo}, {30'd0, 1'b1, v[13]});
    end
  endtask

  task automatic closeFrame(string req);
    csN = 1'b1;
    waitCyc(LAT);
    check(req, "deselect en/sdo", {30'd0, sdoEn, sdo}, 32'd0);
  endtask

  initial begin
    logic [13:0] v;
    logic [13:0] v2;
    void'($urandom(32'h5EED_0A1C));

    waitCyc(4);
    check("R1", "in reset en/sdo", {30'd0, sdoEn, sdo}, 32'd0);
    rst_n = 1'b1;
    waitCyc(4);
    check("R1", "after reset en/sdo", {30'd0, sdoEn, sdo}, 32'd0);

    // R5 R6: chip-select framing, full 17-edge frame, extra edges ignored
    v = 14'h2A5C;
    loadResult(v);
    openFrame(1'b0, v);
    pulses(1);
    check("R5", "msb held on edge 1", {31'd0, got[0]}, {31'd0, v[13]});
    pulses(15);
    check("R5", "cs word", {16'd0, got}, {16'd0, expWord(v)});
    pulses(1);
    check("R6", "released at edge 17", {31'd0, sdoEn}, 32'd0);
    pulses(3);
    check("R6", "stays released", {30'd0, sdoEn, sdo}, 32'd0);
    closeFrame("R2");

    // R7: host stops at 16 edges, chip select releases
    v = 14'h3FFF;
    loadResult(v);
    openFrame(1'b0, v);
    pulses(16);
    check("R5", "all-ones word", {16'd0, got}, {16'd0, expWord(v)});
    check("R7", "still driving after 16", {31'd0, sdoEn}, 32'd1);
    closeFrame("R7");

    // R7: early deselect after 5 edges
    v = 14'h0001;
    loadResult(v);
    openFrame(1'b0, v);
    pulses(5);
    closeFrame("R7");

    // R4 R6: frame-sync framing
    v = 14'h1234;
    loadResult(v);
    openFrame(1'b1, v);
    pulses(16);
    check("R4", "fs word", {16'd0, got}, {16'd0, expWord(v)});
    pulses(1);
    check("R6", "fs release edge 17", {31'd0, sdoEn}, 32'd0);
    closeFrame("R2");

    // R8: update mid-frame does not touch the word in flight
    v  = 14'h0AAA;
    v2 = 14'h1555;
    loadResult(v);
    openFrame(1'b0, v);
    pulses(4);
    loadResult(v2);
    pulses(12);
    check("R8", "word kept mid-update", {16'd0, got}, {16'd0, expWord(v)});
    closeFrame("R2");
    openFrame(1'b0, v2);
    pulses(16);
    check("R8", "next frame new value", {16'd0, got}, {16'd0, expWord(v2)});
    closeFrame("R2");

    // R9: frame-sync toggles inside an open frame are ignored
    v = 14'h2C3B;
    loadResult(v);
    openFrame(1'b0, v);
    pulses(6);
    fsync = 1'b0;
    waitCyc(LAT);
    fsync = 1'b1;
    waitCyc(LAT);
    check("R9", "enable after fs toggle", {31'd0, sdoEn}, 32'd1);
    pulses(10);
    check("R9", "word after fs toggle", {16'd0, got}, {16'd0, expWord(v)});
    closeFrame("R2");

    // random frames, both framings, both terminations
    for (int f = 0; f < 24; f++) begin
      bit dsp;
      bit full;
      v    = 14'($urandom);
      dsp  = 1'($urandom);
      full = 1'($urandom);
      loadResult(v);
      openFrame(dsp, v);
      pulses(16);
      check("R5", "random word", {16'd0, got}, {16'd0, expWord(v)});
      if (full) begin
        pulses(1);
        check("R6", "random release", {31'd0, sdoEn}, 32'd0);
        closeFrame("R2");
      end else begin
        closeFrame("R7");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule